// File: doc/BRIEF.md
# Three-Colour Linear Sensor Line Timer

This block produces all of the digital drive waveforms that a three-colour linear charge-coupled image sensor needs, one scan line at a time. Every duration is counted in master-clock cycles. Each line begins with a charge-transfer window. In that window the phase-1 shift clock is parked high, with a hold time on both sides of the transfer-gate pulse, and a guard interval follows before pixel clocking starts. After that, each pixel period carries complementary shift clocks, a reset-gate pulse at its start and, in the per-bit clamp mode, a clamp pulse a programmable gap later.

The first cycle of each line raises a one-cycle line-start strobe. During pixel clocking the block drives a 1-based pixel index and one-hot region flags for optical-black, dummy and active pixels. These change on the same cycle as the rising edge of the reset gate. The number of pixel periods per line is programmable, so it also sets the integration time. A new configuration word is taken only when a line starts, so the line in progress always uses a single consistent set of timings.

Top module: `ccd_line_timer`

## Requirements
- R1: A line lasts exactly 2·HOLD + XFER + GUARD + NPIX·PIX master cycles. `line_start` is high for the first cycle of each line and low otherwise. The first line starts one cycle after reset is released. All configuration counts must be at least 1, and PIX must be at least 2.
- R2: All XFER_CH transfer-gate outputs are high together for exactly XFER cycles, beginning HOLD cycles after the line start.
- R3: From the line start through the end of the guard interval, `shift1` and `shift1_last` are high and `shift2` is low.
- R4: In each pixel period of PIX cycles, `shift1` and `shift1_last` are high for cycle offsets c where 2·c < PIX. `shift2` is the complement of `shift1`.
- R5: In bit mode (`cfg_line_mode`=0), `rgate` is high from the line start until the end of the post-transfer hold, low in the guard interval, and high for offsets c < RGATE in each pixel period.
- R6: In bit mode, `clamp` is high for offsets RGATE+GAP ≤ c < RGATE+GAP+CLAMP in each pixel period and low everywhere else in the line.
- R7: In line mode (`cfg_line_mode`=1), `clamp` is low from the line start until the end of the post-transfer hold and high otherwise. `rgate` is low while `clamp` is low, and is high for offsets c < RGATE in each pixel period.
- R8: `pix_idx` equals k (1..NPIX) during the k-th pixel period and 0 outside pixel clocking.
- R9: With the count from 1, `in_black` is set for LEAD < k ≤ LEAD+BLACK, `in_dummy` for the DUMMY pixels after that and for the DUMMY pixels after the active run, and `in_active` for the ACTIVE pixels in between. At most one flag is set at any time.
- R10: Configuration inputs are sampled only on the clock edge that starts a line. A change in mid-line leaves the rest of that line unchanged.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_line_mode | input | 1 | 0 = per-bit clamp, 1 = per-line clamp |
| cfg_hold | input | 16 | Shift-clock hold before and after the transfer pulse, in cycles |
| cfg_xfer | input | 16 | Transfer-gate pulse width, in cycles |
| cfg_guard | input | 16 | Guard between the transfer window and pixel clocking, in cycles |
| cfg_pix | input | 16 | Pixel period, in cycles |
| cfg_rgate | input | 16 | Reset-gate pulse width, in cycles |
| cfg_gap | input | 16 | Cycles from reset-gate fall to clamp rise (bit mode) |
| cfg_clamp | input | 16 | Clamp pulse width, in cycles (bit mode) |
| cfg_npix | input | 16 | Pixel periods per line |
| shift1 | output | 1 | Phase-1 shift clock |
| shift2 | output | 1 | Phase-2 shift clock |
| shift1_last | output | 1 | Last-stage copy of phase 1 |
| xfer | output | XFER_CH | Transfer-gate pulses, one per colour |
| rgate | output | 1 | Reset-gate pulse |
| clamp | output | 1 | Clamp pulse |
| line_start | output | 1 | One-cycle strobe at line start |
| pix_idx | output | 16 | Current pixel number, 0 outside pixel clocking |
| in_black | output | 1 | Optical-black pixel flag |
| in_dummy | output | 1 | Dummy pixel flag |
| in_active | output | 1 | Active pixel flag |

## Verification
If the phase counter or the pixel counter goes wrong, the effect shows at the ports within one pixel period. The shift-clock duty, the reset-gate width and the clamp placement drift in the first pixel that follows, and `pix_idx` or the region flags step to the wrong pixel. A wrong line-end decision or a wrong length for the transfer window moves `line_start` and the transfer pulses by whole cycles, and the cycle-by-cycle comparison catches this in the next line. If the configuration capture is wrong, a mid-line change already alters the current line, so the mismatch appears within a few cycles of the write.

// File: rtl/ccd_tim_pkg.sv
package ccd_tim_pkg;
  localparam int CFG_W = 16;
  localparam int IDX_W = 16;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_XFER, PH_POST, PH_GUARD, PH_PIX
  } phase_e;

  typedef struct packed {
    logic             line_mode;
    logic [CFG_W-1:0] hold;
    logic [CFG_W-1:0] xfer;
    logic [CFG_W-1:0] guard;
    logic [CFG_W-1:0] pix;
    logic [CFG_W-1:0] rgate;
    logic [CFG_W-1:0] gap;
    logic [CFG_W-1:0] clamp;
    logic [IDX_W-1:0] npix;
  } cfg_t;

  // final cycle of a phase lasting len cycles
  function automatic logic is_last(input logic [CFG_W-1:0] cnt, input logic [CFG_W-1:0] len);
    return cnt == (len - 1'b1);
  endfunction

  // first (larger) half of a pixel period
  function automatic logic first_half(input logic [CFG_W-1:0] c, input logic [CFG_W-1:0] p);
    return c < (p - (p >> 1));
  endfunction

  // c inside [a+b, a+b+len)
  function automatic logic in_span(input logic [CFG_W-1:0] c, input logic [CFG_W-1:0] a,
                                   input logic [CFG_W-1:0] b, input logic [CFG_W-1:0] len);
    logic [CFG_W+1:0] lo, hi, cc;
    lo = {2'b00, a} + {2'b00, b};
    hi = lo + {2'b00, len};
    cc = {2'b00, c};
    return (cc >= lo) && (cc < hi);
  endfunction
endpackage

// File: rtl/ccd_cfg_latch.sv
module ccd_cfg_latch
  import ccd_tim_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  cfg_t cfg_in,
  output cfg_t cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (load) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
  import ccd_tim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] hold,
  input  logic [CFG_W-1:0] xfer_len,
  input  logic [CFG_W-1:0] guard,
  input  logic [CFG_W-1:0] pix,
  input  logic [IDX_W-1:0] npix,
  output phase_e           phase,
  output logic [CFG_W-1:0] cnt,
  output logic [IDX_W-1:0] idx,
  output logic             load_cfg,
  output logic             line_start
);
  logic pix_end, line_end;

  assign pix_end    = (phase == PH_PIX) && is_last(cnt, pix);
  assign line_end   = pix_end && (idx == npix);
  assign load_cfg   = (phase == PH_IDLE) || line_end;
  assign line_start = (phase == PH_PRE) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      idx   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          phase <= PH_PRE;
          cnt   <= '0;
        end
        PH_PRE: begin
          if (is_last(cnt, hold)) begin phase <= PH_XFER; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        PH_XFER: begin
          if (is_last(cnt, xfer_len)) begin phase <= PH_POST; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        PH_POST: begin
          if (is_last(cnt, hold)) begin phase <= PH_GUARD; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        PH_GUARD: begin
          if (is_last(cnt, guard)) begin
            phase <= PH_PIX;
            cnt   <= '0;
            idx   <= IDX_W'(1);
          end else cnt <= cnt + 1'b1;
        end
        PH_PIX: begin
          if (pix_end) begin
            cnt <= '0;
            if (line_end) begin
              phase <= PH_PRE;
              idx   <= '0;
            end else idx <= idx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
          idx   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/ccd_pulse_gen.sv
module ccd_pulse_gen
  import ccd_tim_pkg::*;
#(
  parameter int LEAD_PIX   = 14,
  parameter int BLACK_PIX  = 48,
  parameter int DUMMY_PIX  = 3,
  parameter int ACTIVE_PIX = 10680,
  parameter int XFER_CH    = 3
) (
  input  phase_e               phase,
  input  logic [CFG_W-1:0]     cnt,
  input  logic [IDX_W-1:0]     idx,
  input  logic                 line_mode,
  input  logic [CFG_W-1:0]     pix,
  input  logic [CFG_W-1:0]     rgate_len,
  input  logic [CFG_W-1:0]     gap,
  input  logic [CFG_W-1:0]     clamp_len,
  output logic                 shift1,
  output logic                 shift2,
  output logic                 shift1_last,
  output logic [XFER_CH-1:0]   xfer,
  output logic                 rgate,
  output logic                 clamp,
  output logic [IDX_W-1:0]     pix_idx,
  output logic                 in_black,
  output logic                 in_dummy,
  output logic                 in_active
);
  localparam logic [IDX_W-1:0] B_END  = IDX_W'(LEAD_PIX + BLACK_PIX);
  localparam logic [IDX_W-1:0] D1_END = IDX_W'(LEAD_PIX + BLACK_PIX + DUMMY_PIX);
  localparam logic [IDX_W-1:0] A_END  = IDX_W'(LEAD_PIX + BLACK_PIX + DUMMY_PIX + ACTIVE_PIX);
  localparam logic [IDX_W-1:0] D2_END = IDX_W'(LEAD_PIX + BLACK_PIX + 2*DUMMY_PIX + ACTIVE_PIX);
  localparam logic [IDX_W-1:0] L_END  = IDX_W'(LEAD_PIX);

  logic active, xfer_win, in_pix, gate_on, head;

  assign active   = (phase != PH_IDLE);
  assign xfer_win = (phase == PH_PRE) || (phase == PH_XFER) || (phase == PH_POST);
  assign in_pix   = (phase == PH_PIX);
  assign gate_on  = (phase == PH_XFER);
  assign head     = in_pix && (cnt < rgate_len);

  always_comb begin
    shift1 = 1'b0;
    if (in_pix)      shift1 = first_half(cnt, pix);
    else if (active) shift1 = 1'b1;
  end

  assign shift2      = active && !shift1;
  assign shift1_last = shift1;

  for (genvar g = 0; g < XFER_CH; g++) begin : g_xfer
    assign xfer[g] = gate_on;
  end

  always_comb begin
    if (line_mode) begin
      rgate = head;
      clamp = active && !xfer_win;
    end else begin
      rgate = xfer_win || head;
      clamp = in_pix && in_span(cnt, rgate_len, gap, clamp_len);
    end
  end

  assign pix_idx   = in_pix ? idx : '0;
  assign in_black  = in_pix && (idx > L_END)  && (idx <= B_END);
  assign in_dummy  = in_pix && (((idx > B_END) && (idx <= D1_END)) ||
                                ((idx > A_END) && (idx <= D2_END)));
  assign in_active = in_pix && (idx > D1_END) && (idx <= A_END);
endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_tim_pkg::*;
#(
  parameter int LEAD_PIX   = 14,
  parameter int BLACK_PIX  = 48,
  parameter int DUMMY_PIX  = 3,
  parameter int ACTIVE_PIX = 10680,
  parameter int XFER_CH    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_line_mode,
  input  logic [CFG_W-1:0]   cfg_hold,
  input  logic [CFG_W-1:0]   cfg_xfer,
  input  logic [CFG_W-1:0]   cfg_guard,
  input  logic [CFG_W-1:0]   cfg_pix,
  input  logic [CFG_W-1:0]   cfg_rgate,
  input  logic [CFG_W-1:0]   cfg_gap,
  input  logic [CFG_W-1:0]   cfg_clamp,
  input  logic [IDX_W-1:0]   cfg_npix,
  output logic               shift1,
  output logic               shift2,
  output logic               shift1_last,
  output logic [XFER_CH-1:0] xfer,
  output logic               rgate,
  output logic               clamp,
  output logic               line_start,
  output logic [IDX_W-1:0]   pix_idx,
  output logic               in_black,
  output logic               in_dummy,
  output logic               in_active
);
  cfg_t             cfg_in, cfg_q;
  phase_e           phase;
  logic [CFG_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic             load_cfg;
  logic             mode_q;

  assign cfg_in = '{line_mode: cfg_line_mode, hold: cfg_hold, xfer: cfg_xfer,
                    guard: cfg_guard, pix: cfg_pix, rgate: cfg_rgate,
                    gap: cfg_gap, clamp: cfg_clamp, npix: cfg_npix};
  assign mode_q = cfg_q.line_mode;

  ccd_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load_cfg), .cfg_in(cfg_in), .cfg_q(cfg_q)
  );

  ccd_line_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .hold(cfg_q.hold), .xfer_len(cfg_q.xfer), .guard(cfg_q.guard),
    .pix(cfg_q.pix), .npix(cfg_q.npix),
    .phase(phase), .cnt(cnt), .idx(idx),
    .load_cfg(load_cfg), .line_start(line_start)
  );

  ccd_pulse_gen #(
    .LEAD_PIX(LEAD_PIX), .BLACK_PIX(BLACK_PIX), .DUMMY_PIX(DUMMY_PIX),
    .ACTIVE_PIX(ACTIVE_PIX), .XFER_CH(XFER_CH)
  ) u_gen (
    .phase(phase), .cnt(cnt), .idx(idx),
    .line_mode(cfg_q.line_mode), .pix(cfg_q.pix), .rgate_len(cfg_q.rgate),
    .gap(cfg_q.gap), .clamp_len(cfg_q.clamp),
    .shift1(shift1), .shift2(shift2), .shift1_last(shift1_last),
    .xfer(xfer), .rgate(rgate), .clamp(clamp), .pix_idx(pix_idx),
    .in_black(in_black), .in_dummy(in_dummy), .in_active(in_active)
  );
endmodule

// File: rtl/ccd_line_timer_chk.sv
module ccd_line_timer_chk
  import ccd_tim_pkg::*;
#(
  parameter int XFER_CH = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               shift1,
  input logic [XFER_CH-1:0] xfer,
  input logic               rgate,
  input logic               clamp,
  input logic               line_start,
  input logic [IDX_W-1:0]   pix_idx,
  input logic               in_black,
  input logic               in_dummy,
  input logic               in_active,
  input logic               mode_q,
  input cfg_t               cfg_q
);
  p_line_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !line_start);

  p_xfer_pre_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer[0]) |-> $past(shift1));

  p_xfer_post_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer[0]) |-> shift1);

  p_xfer_rgate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer[0] && !mode_q) |-> rgate);

  p_line_clamp_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !clamp) |-> !rgate);

  p_active_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_active |-> (pix_idx != '0));

  p_flags_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_black, in_dummy, in_active}));

  p_cfg_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |-> $stable(cfg_q));
endmodule

bind ccd_line_timer ccd_line_timer_chk #(.XFER_CH(XFER_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift1(shift1), .xfer(xfer), .rgate(rgate),
  .clamp(clamp), .line_start(line_start), .pix_idx(pix_idx),
  .in_black(in_black), .in_dummy(in_dummy), .in_active(in_active),
  .mode_q(mode_q), .cfg_q(cfg_q)
);

// File: tb/tb_ccd_line_timer.sv
module tb_ccd_line_timer;
  localparam int LEAD = 2, BLK = 3, DUM = 2, ACT = 5, NCH = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic mode;
  logic [15:0] c_hold, c_xfer, c_guard, c_pix, c_rg, c_gap, c_cl, c_np;
  logic s1, s2, s1l, rg, cl, ls, fb, fd, fa;
  logic [NCH-1:0] xf;
  logic [15:0] idx;

  ccd_line_timer #(.LEAD_PIX(LEAD), .BLACK_PIX(BLK), .DUMMY_PIX(DUM),
                   .ACTIVE_PIX(ACT), .XFER_CH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_line_mode(mode), .cfg_hold(c_hold),
    .cfg_xfer(c_xfer), .cfg_guard(c_guard), .cfg_pix(c_pix), .cfg_rgate(c_rg),
    .cfg_gap(c_gap), .cfg_clamp(c_cl), .cfg_npix(c_np),
    .shift1(s1), .shift2(s2), .shift1_last(s1l), .xfer(xf), .rgate(rg),
    .clamp(cl), .line_start(ls), .pix_idx(idx), .in_black(fb),
    .in_dummy(fd), .in_active(fa));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int aM, aH, aT, aG, aP, aR, aGp, aC, aN, L;
  int t;
  bit first, midchg;
  int e_ls, e_x, e_s1, e_rg, e_cl, e_idx, e_b, e_d, e_a;
  int zone;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s t=%0d act=%0d exp=%0d", tag, t, act, exp);
    end
  endtask

  task automatic set_cfg(input int m, input int h, input int x, input int g, input int p,
                         input int r, input int gp, input int c, input int n);
    mode = m[0]; c_hold = 16'(h); c_xfer = 16'(x); c_guard = 16'(g); c_pix = 16'(p);
    c_rg = 16'(r); c_gap = 16'(gp); c_cl = 16'(c); c_np = 16'(n);
  endtask

  // zone: 0 pre, 1 transfer, 2 post, 3 guard, 4 pixels
  task automatic predict(input int tt);
    int base, k, c;
    base = 2*aH + aT + aG;
    k = 0; c = 0;
    if (tt < aH) zone = 0;
    else if (tt < aH + aT) zone = 1;
    else if (tt < 2*aH + aT) zone = 2;
    else if (tt < base) zone = 3;
    else begin
      zone = 4;
      k = (tt - base) / aP + 1;
      c = (tt - base) - (k - 1) * aP;
    end
    e_ls  = (tt == 0);
    e_x   = (zone == 1);
    e_s1  = (zone == 4) ? (2*c < aP) : 1;
    if (aM == 1) begin
      e_rg = (zone == 4) && (c < aR);
      e_cl = (zone >= 3);
    end else begin
      e_rg = (zone <= 2) || ((zone == 4) && (c < aR));
      e_cl = (zone == 4) && (c >= aR + aGp) && (c < aR + aGp + aC);
    end
    e_idx = k;
    e_b = (k > LEAD) && (k <= LEAD + BLK);
    e_d = ((k > LEAD + BLK) && (k <= LEAD + BLK + DUM)) ||
          ((k > LEAD + BLK + DUM + ACT) && (k <= LEAD + BLK + 2*DUM + ACT));
    e_a = (k > LEAD + BLK + DUM) && (k <= LEAD + BLK + DUM + ACT);
  endtask

  task automatic step();
    int tc;
    string ltag, stag, rtag, ctag;
    @(negedge clk);
    if (!rst_n) begin
      chk({s1, s2, s1l, rg, cl, ls, fb, fd, fa} == 9'd0 && xf == '0 && idx == '0,
          "R11 reset outputs", int'({s1, s2, rg, cl, ls}), 0);
      return;
    end
    if (first) tc = 0;
    else begin
      tc = t + 1;
      if (tc == L) tc = 0;
    end
    first = 0;
    ltag = "R1 line_start";
    if (tc == 0) begin
      if (midchg) ltag = "R10 line_start after mid-line change";
      midchg = 0;
      aM = int'(mode); aH = int'(c_hold); aT = int'(c_xfer); aG = int'(c_guard);
      aP = int'(c_pix); aR = int'(c_rg); aGp = int'(c_gap); aC = int'(c_cl);
      aN = int'(c_np);
      L = 2*aH + aT + aG + aN*aP;
    end
    t = tc;
    predict(tc);
    stag = (zone == 4) ? "R4 shift clocks" : "R3 shift clocks";
    rtag = (aM == 1) ? "R7 rgate" : "R5 rgate";
    ctag = (aM == 1) ? "R7 clamp" : "R6 clamp";
    if (midchg) begin rtag = {rtag, " R10"}; ctag = {ctag, " R10"}; end
    chk(int'(ls) == e_ls, ltag, int'(ls), e_ls);
    chk(xf == {NCH{e_x[0]}}, "R2 xfer", int'(xf), e_x);
    chk(int'(s1) == e_s1 && s1l == s1 && s2 == !s1, stag, int'({s1, s1l, s2}), e_s1);
    chk(int'(rg) == e_rg, rtag, int'(rg), e_rg);
    chk(int'(cl) == e_cl, ctag, int'(cl), e_cl);
    chk(int'(idx) == e_idx, "R8 pix_idx", int'(idx), e_idx);
    chk(int'({fb, fd, fa}) == (e_b*4 + e_d*2 + e_a), "R9 region flags",
        int'({fb, fd, fa}), e_b*4 + e_d*2 + e_a);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    rst_n = 1'b0; first = 1; midchg = 0; t = 0; L = 1;
    set_cfg(0, 3, 5, 2, 6, 1, 1, 2, 15);
    run(3);
    rst_n = 1'b1;
    run(150);
    set_cfg(1, 2, 4, 3, 5, 2, 0, 1, 16); midchg = 1;
    run(300);
    set_cfg(0, 1, 1, 1, 7, 2, 0, 3, 20); midchg = 1;
    run(400);
    set_cfg(0, 2, 3, 1, 2, 1, 0, 1, 14); midchg = 1;
    run(150);
    rst_n = 1'b0;
    run(2);
    set_cfg(1, 4, 6, 2, 4, 1, 2, 1, 15);
    first = 1; midchg = 0;
    rst_n = 1'b1;
    run(300);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule